// File: doc/BRIEF.md
# Hard-Sectored Disk Sector Separator

This block watches the photosensor input of a hard-sectored disk with sixteen sector holes per track and one additional index hole placed half way between the hole that ends sector 15 and the hole that starts sector 0. It turns each sector hole into a short active-low strobe and keeps a 4-bit count of the sector now under the head. It also drives three timing windows that start at every sector boundary: a short "sector valid" flag, a read-synchronisation window and a write-preamble window.

The index hole is recognised purely by timing. Every sector hole opens a guard window of about three quarters of a sector period, and a hole edge that arrives while that guard is still open is taken as the index. The index makes no strobe and restarts no window. It loads the counter with 15, so the next sector hole reads as sector 0, and it raises a `locked` output that stays high until reset. Every duration is a parameter in cycles of the single system clock. The raw input passes through a two-flop synchroniser and a rising-edge detector before any timing logic.

Top module: `sector_hole_tracker`

## Requirements
- R1: After reset, `sec_strobe_n` is 1; `sec_valid`, `rd_sync_win`, `wr_pre_win` and `locked` are 0; `sec_num` is 0.
- R2: Only the rising edge of `hole_in` is acted on, so a hole held high for several cycles produces exactly one event.
- R3: The first hole edge after reset, and any hole edge arriving more than `GUARD_CYC` cycles after the last sector event, is a sector event: `sec_strobe_n` goes to 0 for exactly `STROBE_CYC` cycles.
- R4: A hole edge arriving within `GUARD_CYC` cycles of the last sector event (a spacing of exactly `GUARD_CYC` included) is the index: it produces no strobe and neither restarts nor stretches any window.
- R5: On each sector event `sec_num` becomes (previous value + 1) modulo 16, updated in the same cycle that `sec_strobe_n` falls.
- R6: The index loads `sec_num` with 15 (all four bits set), so the next sector event shows 0.
- R7: `locked` is 0 until the first index after reset, becomes 1 the cycle after it and stays 1 until reset.
- R8: `sec_valid` rises `VALID_DLY_CYC` cycles after `sec_strobe_n` falls and is high for exactly `VALID_CYC` cycles; `sec_num` does not change in the cycle it rises.
- R9: `rd_sync_win` rises in the cycle `sec_strobe_n` falls and is high for exactly `RD_SYNC_CYC` cycles.
- R10: `wr_pre_win` rises in the cycle `sec_strobe_n` falls and is high for exactly `WR_PRE_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hole_in | input | 1 | Raw hole sensor, 1 while a hole is under the sensor |
| sec_strobe_n | output | 1 | Active-low strobe, one per sector hole |
| sec_valid | output | 1 | Sector-valid flag, delayed after the boundary |
| sec_num | output | 4 | Number of the sector under the head |
| locked | output | 1 | High once an index has been seen |
| rd_sync_win | output | 1 | Read-synchronisation window |
| wr_pre_win | output | 1 | Write-preamble window |

## Verification
On every cycle the assertions check that the count steps by one exactly where the strobe falls, that an index loads 15, raises `locked` and is never followed by a strobe, that `locked` never drops, and that the flag and both windows only open at a strobe or with the count settled. Exact window and strobe lengths, the guard boundary at a spacing of exactly `GUARD_CYC` versus one more, the count sequence over whole revolutions, and the fact that an index inside an open write-preamble window does not stretch it can only be shown by the bench's hole trains.

// File: rtl/sector_sep_pkg.sv
package sector_sep_pkg;

  localparam int unsigned SEC_W = 4;
  localparam logic [SEC_W-1:0] INDEX_LOAD = '1;

  localparam int unsigned WIN_STROBE = 0;
  localparam int unsigned WIN_GUARD  = 1;
  localparam int unsigned WIN_VALID  = 2;
  localparam int unsigned WIN_RDSYNC = 3;
  localparam int unsigned WIN_WRPRE  = 4;
  localparam int unsigned WIN_N      = 5;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned span_end(input int unsigned start, input int unsigned len);
    return start + len;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic logic [SEC_W-1:0] sector_after(input logic [SEC_W-1:0] cur);
    return cur + 1'b1;
  endfunction

endpackage

// File: rtl/hole_edge_sync.sv
module hole_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
endmodule

// File: rtl/span_decode.sv
module span_decode #(
  parameter int unsigned TW    = 8,
  parameter int unsigned START = 0,
  parameter int unsigned LEN   = 1
) (
  input  logic          active,
  input  logic [TW-1:0] elapsed,
  output logic          open
);
  localparam logic [TW-1:0] S_V = TW'(START);
  localparam logic [TW-1:0] E_V = TW'(START + LEN);

  assign open = active && (elapsed >= S_V) && (elapsed < E_V);
endmodule

// File: rtl/boundary_timer.sv
module boundary_timer
  import sector_sep_pkg::*;
#(
  parameter int unsigned STROBE_CYC    = 20,
  parameter int unsigned GUARD_CYC     = 187500,
  parameter int unsigned VALID_DLY_CYC = 4,
  parameter int unsigned VALID_CYC     = 600,
  parameter int unsigned RD_SYNC_CYC   = 14000,
  parameter int unsigned WR_PRE_CYC    = 24000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [WIN_N-1:0] win
);
  localparam int unsigned LIMIT =
    max2(max2(max2(STROBE_CYC, GUARD_CYC), span_end(VALID_DLY_CYC, VALID_CYC)),
         max2(RD_SYNC_CYC, WR_PRE_CYC));
  localparam int unsigned TW = bits_for(LIMIT);
  localparam logic [TW-1:0] LIMIT_V = TW'(LIMIT);

  localparam int unsigned W_START [WIN_N] = '{0, 0, VALID_DLY_CYC, 0, 0};
  localparam int unsigned W_LEN   [WIN_N] = '{STROBE_CYC, GUARD_CYC, VALID_CYC,
                                              RD_SYNC_CYC, WR_PRE_CYC};

  logic          active_q;
  logic [TW-1:0] elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      elapsed_q <= '0;
    end else if (restart) begin
      active_q  <= 1'b1;
      elapsed_q <= '0;
    end else if (active_q && (elapsed_q != LIMIT_V)) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  for (genvar g = 0; g < WIN_N; g++) begin : g_win
    span_decode #(.TW(TW), .START(W_START[g]), .LEN(W_LEN[g])) dec_i (
      .active (active_q),
      .elapsed(elapsed_q),
      .open   (win[g])
    );
  end
endmodule

// File: rtl/sector_counter.sv
module sector_counter
  import sector_sep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_evt,
  input  logic             idx_evt,
  output logic [SEC_W-1:0] count,
  output logic             locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      locked <= 1'b0;
    end else if (idx_evt) begin
      count  <= INDEX_LOAD;
      locked <= 1'b1;
    end else if (sec_evt) begin
      count  <= sector_after(count);
    end
  end
endmodule

// File: rtl/sector_hole_tracker.sv
module sector_hole_tracker
  import sector_sep_pkg::*;
#(
  parameter int unsigned STROBE_CYC    = 20,
  parameter int unsigned GUARD_CYC     = 187500,
  parameter int unsigned VALID_DLY_CYC = 4,
  parameter int unsigned VALID_CYC     = 600,
  parameter int unsigned RD_SYNC_CYC   = 14000,
  parameter int unsigned WR_PRE_CYC    = 24000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hole_in,
  output logic       sec_strobe_n,
  output logic       sec_valid,
  output logic [3:0] sec_num,
  output logic       locked,
  output logic       rd_sync_win,
  output logic       wr_pre_win
);
  logic             hole_rise;
  logic             guard_open;
  logic             sec_evt;
  logic             idx_evt;
  logic [WIN_N-1:0] win;

  hole_edge_sync sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_in(hole_in),
    .rise  (hole_rise)
  );

  // A hole edge inside the guard of the last sector hole is the index.
  assign guard_open = win[WIN_GUARD];
  assign idx_evt    = hole_rise &  guard_open;
  assign sec_evt    = hole_rise & ~guard_open;

  boundary_timer #(
    .STROBE_CYC   (STROBE_CYC),
    .GUARD_CYC    (GUARD_CYC),
    .VALID_DLY_CYC(VALID_DLY_CYC),
    .VALID_CYC    (VALID_CYC),
    .RD_SYNC_CYC  (RD_SYNC_CYC),
    .WR_PRE_CYC   (WR_PRE_CYC)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(sec_evt),
    .win    (win)
  );

  sector_counter cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sec_evt(sec_evt),
    .idx_evt(idx_evt),
    .count  (sec_num),
    .locked (locked)
  );

  assign sec_strobe_n = ~win[WIN_STROBE];
  assign sec_valid    = win[WIN_VALID];
  assign rd_sync_win  = win[WIN_RDSYNC];
  assign wr_pre_win   = win[WIN_WRPRE];
endmodule

// File: rtl/sector_hole_tracker_chk.sv
module sector_hole_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_strobe_n,
  input logic       sec_valid,
  input logic [3:0] sec_num,
  input logic       locked,
  input logic       rd_sync_win,
  input logic       wr_pre_win,
  input logic       sec_evt,
  input logic       idx_evt
);
  // R3
  sector_event_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> !sec_strobe_n);

  // R4
  index_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> !$fell(sec_strobe_n));

  // R5
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_strobe_n) |-> (sec_num == 4'($past(sec_num) + 4'd1)));

  // R6
  index_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> (sec_num == 4'hF));

  // R7
  locked_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> locked);

  // R7
  locked_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked));

  // R8
  valid_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_valid) |-> $stable(sec_num));

  // R9
  rdsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_sync_win) |-> $fell(sec_strobe_n));

  // R10
  wrpre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pre_win) |-> $fell(sec_strobe_n));
endmodule

bind sector_hole_tracker sector_hole_tracker_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_strobe_n(sec_strobe_n),
  .sec_valid   (sec_valid),
  .sec_num     (sec_num),
  .locked      (locked),
  .rd_sync_win (rd_sync_win),
  .wr_pre_win  (wr_pre_win),
  .sec_evt     (sec_evt),
  .idx_evt     (idx_evt)
);

// File: tb/sector_hole_tracker_tb_top.sv
`timescale 1ns/1ps
module sector_hole_tracker_tb_top;
  localparam int STROBE = 4;
  localparam int GUARD  = 75;
  localparam int VDLY   = 2;
  localparam int VLEN   = 6;
  localparam int RSYNC  = 20;
  localparam int WPRE   = 60;
  localparam int PERIOD = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hole_in = 1'b0;
  logic sec_strobe_n, sec_valid, locked, rd_sync_win, wr_pre_win;
  logic [3:0] sec_num;

  always #2 clk = ~clk;

  sector_hole_tracker #(
    .STROBE_CYC(STROBE), .GUARD_CYC(GUARD), .VALID_DLY_CYC(VDLY),
    .VALID_CYC(VLEN), .RD_SYNC_CYC(RSYNC), .WR_PRE_CYC(WPRE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hole_in(hole_in),
    .sec_strobe_n(sec_strobe_n), .sec_valid(sec_valid), .sec_num(sec_num),
    .locked(locked), .rd_sync_win(rd_sync_win), .wr_pre_win(wr_pre_win)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // generator bookkeeping
  int gen_sectors = 0;
  bit idx_pending = 0;
  bit seen_idx = 0;

  task automatic emit(input bit is_idx, input int width, input int gap);
    @(posedge clk); #1;
    if (is_idx) begin idx_pending = 1; seen_idx = 1; end
    else gen_sectors++;
    hole_in = 1'b1;
    repeat (width) @(posedge clk);
    #1 hole_in = 1'b0;
    repeat (gap - width - 1) @(posedge clk);
  endtask

  // monitor
  bit mon_on = 0;
  logic prev_sn = 1'b1, prev_v = 1'b0, prev_r = 1'b0, prev_w = 1'b0;
  logic [3:0] prev_cnt = 4'd0;
  logic [3:0] last_cnt = 4'd0;
  int pulses = 0, age = 1000, lowlen = 0, vlen = 0, rlen = 0, wlen = 0;

  always @(negedge clk) if (mon_on) begin
    automatic bit fell = prev_sn && !sec_strobe_n;
    if (age < 1000) age++;
    if (fell) begin
      automatic logic [3:0] exp = idx_pending ? 4'd0 : 4'(last_cnt + 4'd1);
      pulses++;
      age = 0;
      lowlen = 1;
      if (idx_pending) chk(sec_num == exp, "R6 count after index", sec_num, exp);
      else             chk(sec_num == exp, "R5 count step", sec_num, exp);
      chk(locked == seen_idx, "R7 locked at strobe", locked, seen_idx);
      chk(rd_sync_win, "R9 window opens with strobe", rd_sync_win, 1);
      chk(wr_pre_win, "R10 window opens with strobe", wr_pre_win, 1);
      last_cnt = sec_num;
      idx_pending = 0;
    end else if (!sec_strobe_n) lowlen++;
    if (!prev_sn && sec_strobe_n) chk(lowlen == STROBE, "R3 strobe length", lowlen, STROBE);
    if (!fell && sec_num != prev_cnt)
      chk(sec_num == 4'hF && idx_pending, "R6 load 15 at index", sec_num, 15);
    if (!prev_v && sec_valid) begin
      chk(age == VDLY, "R8 valid delay", age, VDLY);
      vlen = 1;
    end else if (sec_valid) vlen++;
    if (prev_v && !sec_valid) chk(vlen == VLEN, "R8 valid length", vlen, VLEN);
    if (!prev_r && rd_sync_win) begin
      chk(fell, "R9 window start", 0, 1); rlen = 1;
    end else if (rd_sync_win) rlen++;
    if (prev_r && !rd_sync_win) chk(rlen == RSYNC, "R9 window length", rlen, RSYNC);
    if (!prev_w && wr_pre_win) begin
      chk(fell, "R10 window start", 0, 1); wlen = 1;
    end else if (wr_pre_win) wlen++;
    if (prev_w && !wr_pre_win) chk(wlen == WPRE, "R10 window length (index must not stretch)", wlen, WPRE);
    prev_sn = sec_strobe_n; prev_v = sec_valid; prev_r = rd_sync_win;
    prev_w = wr_pre_win; prev_cnt = sec_num;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sec_strobe_n == 1'b1, "R1 strobe idle", sec_strobe_n, 1);
    chk(sec_valid == 1'b0, "R1 valid idle", sec_valid, 0);
    chk(rd_sync_win == 1'b0, "R1 read window idle", rd_sync_win, 0);
    chk(wr_pre_win == 1'b0, "R1 write window idle", wr_pre_win, 0);
    chk(sec_num == 4'd0, "R1 count", sec_num, 0);
    chk(locked == 1'b0, "R1 locked", locked, 0);
    mon_on = 1;
    // unsynchronised sectors, then the index half a period later
    for (int i = 0; i < 3; i++) emit(0, 3, PERIOD);
    chk(locked == 1'b0, "R7 locked before index", locked, 0);
    emit(0, 3, PERIOD / 2);
    emit(1, 3, PERIOD / 2);
    // two full revolutions
    for (int rev = 0; rev < 2; rev++)
      for (int s = 0; s < 16; s++) begin
        if (s == 15) begin
          emit(0, 3, PERIOD / 2);
          emit(1, 3, PERIOD / 2);
        end else emit(0, 3, PERIOD);
      end
    chk(pulses == gen_sectors, "R4 no strobe at index", pulses, gen_sectors);
    // stray edge inside open write window is taken as index
    emit(0, 3, 20);
    emit(1, 3, PERIOD - 20);
    // guard boundary: spacing GUARD is index, GUARD+1 is sector
    emit(0, 3, GUARD);
    emit(1, 3, PERIOD - GUARD);
    emit(0, 3, GUARD + 1);
    emit(0, 3, PERIOD);
    // long hole gives one event only
    begin
      automatic int p0 = pulses;
      emit(0, 12, PERIOD);
      chk(pulses == p0 + 1, "R2 one event per long hole", pulses, p0 + 1);
    end
    chk(pulses == gen_sectors, "R4 strobes equal sector holes", pulses, gen_sectors);
    chk(locked == 1'b1, "R7 locked stays high", locked, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule